// File: doc/BRIEF.md
# Triggered Hand-off Request Multiplexer

This block controls a process that runs as a small state machine until it reaches one of several exit states, and then passes control to a child process that has been waiting. The controller is held as a one-hot state register. Its states split into choice states, where it waits for a transition, and exit states. Each exit state drives one wake line to one child. On entering an exit state the controller raises that wake line for exactly one cycle, and then drops to an empty state register. From then on it requests nothing and ignores all transition commands.

The requests that leave the block pass through a chain of selector stages, one per child. After reset every stage passes on the requests from the stage before it, so the output carries the controller's own requests. A stage that sees its child's wake pulse latches permanently. From the next cycle on it drives its child's synchronisation request and event requests. The end of the chain therefore always shows the requests of whichever process is active. Only a reset returns the chain to pass-through and the controller to its initial state. The child processes lie outside the block: their request lines are inputs.

Top module: `hoff_req_mux`

## Requirements
- R1: After reset the controller is in choice state 0, every wake line is 0, no stage is latched, and `up_evt_req` equals the state-0 event pattern 4'h5.
- R2: In choice state i (0..3), `up_sync_req` equals `go_valid` and `up_evt_req` equals (5 + 3*i) mod 16. A `go_valid` with `go_state` in 0..3 moves the controller to that choice state at the next clock edge.
- R3: A `go_valid` in a choice state with `go_state` = 4+k (k in 0..2) puts the controller in exit state k. In the following cycle `wake[k]` is 1 and every other wake line is 0. That wake pulse lasts exactly one cycle.
- R4: After its exit cycle the controller holds no active state. It ignores `go_valid` and never raises another wake line until reset.
- R5: While no stage is latched, `up_sync_req` and `up_evt_req` are the controller's requests, and all child request inputs have no effect on them.
- R6: From the cycle after `wake[k]`, `up_sync_req` equals `child_sync_req[k]` and `up_evt_req` equals `child_evt_req[4*k+3:4*k]`.
- R7: A `go_valid` with `go_state` = 7, which names no state, is ignored, and the controller stays in its current choice state.
- R8: A latched stage stays latched until reset. A reset restores pass-through of the controller's requests.
- R9: During the exit cycle and during dormancy, the controller's own requests are zero, so `up_sync_req` and `up_evt_req` are 0 in the exit cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| go_valid | input | 1 | Transition command for the controller |
| go_state | input | 3 | Target state: 0..3 choice, 4..6 exit k=go_state-4, 7 invalid |
| child_sync_req | input | 3 | Synchronisation request of each child |
| child_evt_req | input | 12 | Event requests, 4 bits per child, child k at bits 4k+3:4k |
| wake | output | 3 | One-cycle wake pulse per child |
| up_sync_req | output | 1 | Synchronisation request of the active process |
| up_evt_req | output | 4 | Event requests of the active process |

## Verification
A controller stuck in a wrong choice state shows up on the same cycle at `up_evt_req` as the wrong pattern. An exit that is lost, or a wake pulse that repeats, shows on the wake lines one cycle after the command. A stage that latches early, late or not at all, or that releases, makes `up_*` follow the wrong source from the cycle after the pulse. The bench drives random child requests every cycle so that this mismatch shows at once. A controller that fails to go dormant shows up as a second wake pulse or as nonzero requests in the exit cycle.

// File: rtl/hoff_pkg.sv
package hoff_pkg;
  localparam int unsigned NUM_CHOICE = 4;
  localparam int unsigned NUM_EXIT   = 3;
  localparam int unsigned EVT_W      = 4;

  // Event request pattern a choice state presents upward (low bits used).
  function automatic logic [31:0] choice_evt_pattern(input int unsigned idx);
    return 32'(idx * 3 + 5);
  endfunction
endpackage

// File: rtl/hoff_ctrl.sv
module hoff_ctrl #(
  parameter int unsigned NUM_CHOICE = hoff_pkg::NUM_CHOICE,
  parameter int unsigned NUM_EXIT   = hoff_pkg::NUM_EXIT,
  parameter int unsigned EVT_W      = hoff_pkg::EVT_W,
  localparam int unsigned NS        = NUM_CHOICE + NUM_EXIT,
  localparam int unsigned SW        = $clog2(NS + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                go_valid,
  input  logic [SW-1:0]       go_state,
  output logic [NUM_EXIT-1:0] wake,
  output logic                ctl_sync_req,
  output logic [EVT_W-1:0]    ctl_evt_req
);
  logic [NS-1:0] state_q, state_d;
  logic          in_choice, in_exit, dormant, go_legal;
  logic [31:0]   cur_idx;
  logic [31:0]   pat;

  assign in_choice = |state_q[NUM_CHOICE-1:0];
  assign in_exit   = |state_q[NS-1:NUM_CHOICE];
  assign dormant   = (state_q == '0);
  assign go_legal  = 32'(go_state) < NS;

  always_comb begin
    cur_idx = '0;
    for (int i = 0; i < int'(NUM_CHOICE); i++)
      if (state_q[i]) cur_idx = 32'(i);
  end

  always_comb begin
    state_d = state_q;
    if (in_exit)
      state_d = '0;
    else if (in_choice && go_valid && go_legal) begin
      state_d = '0;
      for (int i = 0; i < int'(NS); i++)
        if (32'(go_state) == 32'(i)) state_d[i] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) state_q <= NS'(1);
    else        state_q <= state_d;

  // Control lines are the exit-state registers themselves.
  assign wake         = state_q[NS-1:NUM_CHOICE];
  assign pat          = hoff_pkg::choice_evt_pattern(cur_idx);
  assign ctl_sync_req = in_choice & go_valid;
  assign ctl_evt_req  = in_choice ? pat[EVT_W-1:0] : '0;

  // R3: at most one wake line at a time, and each pulse lasts one cycle
  a_r3_wake_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wake));
  a_r3_wake_single: assert property (@(posedge clk) disable iff (!rst_n)
    (wake != '0) |=> (wake == '0));
  // R4: once dormant, no state ever comes back before reset
  a_r4_dormant_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == '0) |=> (state_q == '0) && (wake == '0));
  // R9: no requests from the controller outside choice states
  a_r9_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (wake != '0 || dormant) |-> (!ctl_sync_req && ctl_evt_req == '0));
  // R7: an illegal target leaves the state untouched
  a_r7_bad_target: assert property (@(posedge clk) disable iff (!rst_n)
    (in_choice && go_valid && !go_legal) |=> $stable(state_q));
endmodule

// File: rtl/hoff_mux_stage.sv
module hoff_mux_stage #(
  parameter int unsigned EVT_W = hoff_pkg::EVT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig,
  input  logic             north_sync,
  input  logic [EVT_W-1:0] north_evt,
  input  logic             west_sync,
  input  logic [EVT_W-1:0] west_evt,
  output logic             out_sync,
  output logic [EVT_W-1:0] out_evt,
  output logic             taken
);
  logic taken_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)    taken_q <= 1'b0;
    else if (trig) taken_q <= 1'b1;

  assign taken    = taken_q;
  assign out_sync = taken_q ? west_sync : north_sync;
  assign out_evt  = taken_q ? west_evt  : north_evt;

  // R8: selection is one-way until reset
  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    taken_q |=> taken_q);
  // R6: a trigger pulse switches the stage on the next cycle
  a_r6_latch: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> taken_q);
endmodule

// File: rtl/hoff_req_mux.sv
module hoff_req_mux #(
  parameter int unsigned NUM_CHOICE = hoff_pkg::NUM_CHOICE,
  parameter int unsigned NUM_EXIT   = hoff_pkg::NUM_EXIT,
  parameter int unsigned EVT_W      = hoff_pkg::EVT_W,
  localparam int unsigned NS        = NUM_CHOICE + NUM_EXIT,
  localparam int unsigned SW        = $clog2(NS + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      go_valid,
  input  logic [SW-1:0]             go_state,
  input  logic [NUM_EXIT-1:0]       child_sync_req,
  input  logic [NUM_EXIT*EVT_W-1:0] child_evt_req,
  output logic [NUM_EXIT-1:0]       wake,
  output logic                      up_sync_req,
  output logic [EVT_W-1:0]          up_evt_req
);
  logic                ctl_sync_req;
  logic [EVT_W-1:0]    ctl_evt_req;
  logic                sync_chain [NUM_EXIT+1];
  logic [EVT_W-1:0]    evt_chain  [NUM_EXIT+1];
  logic [NUM_EXIT-1:0] stage_taken;

  hoff_ctrl #(.NUM_CHOICE(NUM_CHOICE), .NUM_EXIT(NUM_EXIT), .EVT_W(EVT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .go_valid(go_valid), .go_state(go_state),
    .wake(wake), .ctl_sync_req(ctl_sync_req), .ctl_evt_req(ctl_evt_req));

  assign sync_chain[0] = ctl_sync_req;
  assign evt_chain[0]  = ctl_evt_req;

  for (genvar k = 0; k < int'(NUM_EXIT); k++) begin : g_stage
    hoff_mux_stage #(.EVT_W(EVT_W)) u_stage (
      .clk(clk), .rst_n(rst_n), .trig(wake[k]),
      .north_sync(sync_chain[k]), .north_evt(evt_chain[k]),
      .west_sync(child_sync_req[k]),
      .west_evt(child_evt_req[k*EVT_W +: EVT_W]),
      .out_sync(sync_chain[k+1]), .out_evt(evt_chain[k+1]),
      .taken(stage_taken[k]));

    // R6: the child woken by wake[k] owns the outputs from the next cycle
    a_r6_handoff: assert property (@(posedge clk) disable iff (!rst_n)
      wake[k] |=> (up_sync_req == child_sync_req[k]) &&
                  (up_evt_req == child_evt_req[k*EVT_W +: EVT_W]));
  end

  assign up_sync_req = sync_chain[NUM_EXIT];
  assign up_evt_req  = evt_chain[NUM_EXIT];

  // R5: pass-through of the controller while no stage has switched
  a_r5_forward: assert property (@(posedge clk) disable iff (!rst_n)
    (stage_taken == '0) |-> (up_sync_req == ctl_sync_req) &&
                            (up_evt_req == ctl_evt_req));
  // R4: at most one child ever takes over
  a_r4_single_owner: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(stage_taken));
endmodule

// File: tb/hoff_req_mux_bench.sv
module hoff_req_mux_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        go_valid = 1'b0;
  logic [2:0]  go_state = '0;
  logic [2:0]  child_sync_req = '0;
  logic [11:0] child_evt_req = '0;
  logic [2:0]  wake;
  logic        up_sync_req;
  logic [3:0]  up_evt_req;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // bench model: 0 choice, 1 exit, 2 dormant
  int m_mode, m_idx, m_exit, m_sel;

  always #4 clk = ~clk;  // 125 MHz

  hoff_req_mux u_hoff_req_mux (
    .clk(clk), .rst_n(rst_n), .go_valid(go_valid), .go_state(go_state),
    .child_sync_req(child_sync_req), .child_evt_req(child_evt_req),
    .wake(wake), .up_sync_req(up_sync_req), .up_evt_req(up_evt_req));

  function automatic logic [3:0] pat_of(input int i);
    logic [3:0] p;
    p = 4'd5;
    for (int n = 0; n < i; n++) p = p + 4'd3;
    return p;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; go_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    m_mode = 0; m_idx = 0; m_exit = 0; m_sel = -1;
    #1;
    check("R1 wake", int'(wake), 0);
    check("R1 evt", int'(up_evt_req), int'(pat_of(0)));
  endtask

  // inputs set at negedge; check combinational result; advance model at posedge
  task automatic step(input bit gv, input int gs);
    logic       es;
    logic [3:0] ee;
    string      tag;
    go_valid = gv; go_state = 3'(gs);
    child_sync_req = 3'($urandom);
    child_evt_req  = 12'($urandom);
    #1;
    check("R3 wake", int'(wake), (m_mode == 1) ? (1 << m_exit) : 0);
    if (m_sel >= 0) begin
      es = child_sync_req[m_sel]; ee = child_evt_req[m_sel*4 +: 4]; tag = "R6 handoff";
    end else if (m_mode == 0) begin
      es = gv; ee = pat_of(m_idx); tag = "R5 R2 controller";
    end else begin
      es = 1'b0; ee = 4'h0; tag = "R9 quiet";
    end
    check({tag, " sync"}, int'(up_sync_req), int'(es));
    check({tag, " evt"}, int'(up_evt_req), int'(ee));
    @(posedge clk);
    if (m_mode == 1) begin
      m_mode = 2; m_sel = m_exit;
    end else if (m_mode == 0 && gv && gs < 7) begin
      if (gs < 4) m_idx = gs;
      else begin m_mode = 1; m_exit = gs - 4; end
    end
    @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd7331));
    @(negedge clk);
    do_reset();
    // R7: invalid target ignored, then R2 directed choice moves
    step(1, 2); step(1, 7); step(0, 0); step(1, 3); step(1, 7); step(0, 0);
    // R3 directed exit to child 2, R4 ignored commands while dormant
    step(1, 6); step(1, 4); step(1, 5); step(1, 0); step(0, 0); step(1, 4);
    // R8: reset restores pass-through
    do_reset();
    step(1, 1); step(0, 0);
    for (int k = 0; k < 3; k++) begin
      do_reset();
      step(1, k); step(1, 4 + k);
      for (int n = 0; n < 6; n++) step(1, int'($urandom_range(0, 7)));
    end
    for (int e = 0; e < 40; e++) begin
      do_reset();
      for (int n = 0; n < 50; n++)
        step(($urandom_range(0, 3) != 0), int'($urandom_range(0, 7)));
    end
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule